// File: doc/BRIEF.md
# DMA Residue Position Calculator

This block answers the question "how many bytes of this transfer are still outstanding?" for a channel that moves data through two ping-pong buffers. On a start pulse it looks at the channel status flags (buffer in use, buffer A armed, buffer B armed). From them it decides which buffer's live address register is the one currently advancing, and it captures that address.

It then walks a small table of transfer segments, each given as a base address and a byte length, one segment per clock. The first segment that holds the captured address contributes the bytes not yet moved in it. Every segment after it contributes its full length. When the walk reaches the programmed segment count, the total appears on `residue` together with a one-cycle `done` pulse. The total stays there until the next walk completes.

The segment table, the count and the buffer addresses are plain parallel inputs. Segment `i` occupies bits `[i*W +: W]` of the flattened base and length buses.

Top module: `dma_residue_calc`

## Requirements
- R1: The address of buffer A is captured when armed_a=1 with in_use=0, or when in_use=1 with armed_b=0.
- R2: In every other flag combination the address of buffer B is captured.
- R3: A segment holds the captured address when the address is at least the segment base and strictly below the base plus the segment length. The address equal to base plus length is outside that segment.
- R4: For the first segment that holds the address, the residue gains its length minus (address minus base). Every later scanned segment adds its full length.
- R5: When no scanned segment holds the address, the residue is 0.
- R6: Only segments with index below seg_count are scanned. A seg_count of 0 yields 0, and a seg_count above NSEG is treated as NSEG.
- R7: `done` is high for exactly one cycle. A start sampled at clock edge E0 raises `done` after edge E(n+1), where n is the effective segment count.
- R8: After reset, `residue` is 0 and `done` is 0. `residue` changes only in the cycle where `done` is high and holds its value otherwise.
- R9: A start pulse sampled while a scan is in progress is ignored. It neither restarts the scan nor produces an extra `done`.
- R10: The active address is captured at the accepted start. Changes to addr_a, addr_b or the flags during the scan do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a residue computation |
| in_use | input | 1 | Status: buffer in use flag |
| armed_a | input | 1 | Status: buffer A started flag |
| armed_b | input | 1 | Status: buffer B started flag |
| addr_a | input | ADDR_W | Live address of buffer A |
| addr_b | input | ADDR_W | Live address of buffer B |
| seg_base | input | NSEG*ADDR_W | Flattened segment base addresses, segment i at [i*ADDR_W +: ADDR_W] |
| seg_len | input | NSEG*LEN_W | Flattened segment lengths, segment i at [i*LEN_W +: LEN_W] |
| seg_count | input | CNT_W | Number of valid segments |
| residue | output | RES_W | Bytes remaining, valid when done |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the segment table and seg_count do not change between an accepted start and the following `done`. They also assume that the segments do not overlap, so the first hit is the only hit.

The stimulus programs one fixed, disjoint table for all vectors and holds it constant. Only the buffer addresses, the flags, the count and the start pulse change between runs. Addresses and flags are deliberately disturbed mid-scan only in the test of R9 and R10, because the design must ignore them there.

// File: rtl/dma_residue_pkg.sv
package dma_residue_pkg;
    localparam int unsigned DEF_ADDR_W = 32;
    localparam int unsigned DEF_LEN_W  = 13;
    localparam int unsigned DEF_NSEG   = 8;

    typedef enum logic {
        BUF_A = 1'b0,
        BUF_B = 1'b1
    } buf_sel_e;
endpackage

// File: rtl/dma_residue_bufsel.sv
module dma_residue_bufsel
    import dma_residue_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W
) (
    input  logic              in_use,
    input  logic              armed_a,
    input  logic              armed_b,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    output buf_sel_e          which,
    output logic [ADDR_W-1:0] addr_sel
);
    // A is advancing if it is armed and no buffer is in use,
    // or if a buffer is in use while B is not armed.
    always_comb begin
        if ((armed_a && !in_use) || (in_use && !armed_b)) begin
            which = BUF_A;
        end else begin
            which = BUF_B;
        end
        addr_sel = (which == BUF_A) ? addr_a : addr_b;
    end
endmodule

// File: rtl/dma_residue_segeval.sv
module dma_residue_segeval #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LEN_W  = 13
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [LEN_W-1:0]  len,
    output logic              hit,
    output logic [LEN_W-1:0]  remain
);
    logic [ADDR_W:0]   limit_x;
    logic [ADDR_W-1:0] offset;

    always_comb begin
        // One extra bit keeps base+len from wrapping at the top of the map.
        limit_x = {1'b0, base} + {{(ADDR_W + 1 - LEN_W){1'b0}}, len};
        hit     = (addr >= base) && ({1'b0, addr} < limit_x);
        offset  = addr - base;
        remain  = len - offset[LEN_W-1:0];
    end
endmodule

// File: rtl/dma_residue_segmux.sv
module dma_residue_segmux #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LEN_W  = 13,
    parameter int unsigned NSEG   = 8,
    localparam int unsigned CNT_W = $clog2(NSEG + 1)
) (
    input  logic [NSEG*ADDR_W-1:0] seg_base,
    input  logic [NSEG*LEN_W-1:0]  seg_len,
    input  logic [CNT_W-1:0]       idx,
    output logic [ADDR_W-1:0]      base_o,
    output logic [LEN_W-1:0]       len_o
);
    logic [ADDR_W-1:0] base_arr [NSEG];
    logic [LEN_W-1:0]  len_arr  [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_unpack
        assign base_arr[g] = seg_base[g*ADDR_W +: ADDR_W];
        assign len_arr[g]  = seg_len[g*LEN_W +: LEN_W];
    end

    always_comb begin
        base_o = '0;
        len_o  = '0;
        for (int i = 0; i < NSEG; i++) begin
            if (idx == CNT_W'(i)) begin
                base_o = base_arr[i];
                len_o  = len_arr[i];
            end
        end
    end
endmodule

// File: rtl/dma_residue_calc.sv
module dma_residue_calc
    import dma_residue_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned LEN_W  = DEF_LEN_W,
    parameter int unsigned NSEG   = DEF_NSEG,
    localparam int unsigned CNT_W = $clog2(NSEG + 1),
    localparam int unsigned RES_W = LEN_W + CNT_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   in_use,
    input  logic                   armed_a,
    input  logic                   armed_b,
    input  logic [ADDR_W-1:0]      addr_a,
    input  logic [ADDR_W-1:0]      addr_b,
    input  logic [NSEG*ADDR_W-1:0] seg_base,
    input  logic [NSEG*LEN_W-1:0]  seg_len,
    input  logic [CNT_W-1:0]       seg_count,
    output logic [RES_W-1:0]       residue,
    output logic                   done
);
    typedef struct packed {
        logic              busy;
        logic              found;
        logic [CNT_W-1:0]  idx;
        logic [CNT_W-1:0]  limit;
        logic [ADDR_W-1:0] cur_addr;
        logic [RES_W-1:0]  acc;
        logic [RES_W-1:0]  residue;
        logic              done;
    } state_t;

    state_t state_d, state_q;

    buf_sel_e          which;
    logic [ADDR_W-1:0] addr_sel;
    logic [ADDR_W-1:0] cur_base;
    logic [LEN_W-1:0]  cur_len;
    logic              cur_hit;
    logic [LEN_W-1:0]  cur_remain;
    logic              scan_busy;

    dma_residue_bufsel #(.ADDR_W(ADDR_W)) u_bufsel (
        .in_use   (in_use),
        .armed_a  (armed_a),
        .armed_b  (armed_b),
        .addr_a   (addr_a),
        .addr_b   (addr_b),
        .which    (which),
        .addr_sel (addr_sel)
    );

    dma_residue_segmux #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .NSEG(NSEG)) u_segmux (
        .seg_base (seg_base),
        .seg_len  (seg_len),
        .idx      (state_q.idx),
        .base_o   (cur_base),
        .len_o    (cur_len)
    );

    dma_residue_segeval #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_segeval (
        .addr   (state_q.cur_addr),
        .base   (cur_base),
        .len    (cur_len),
        .hit    (cur_hit),
        .remain (cur_remain)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        if (!state_q.busy) begin
            if (start) begin
                state_d.busy     = 1'b1;
                state_d.found    = 1'b0;
                state_d.idx      = '0;
                state_d.acc      = '0;
                state_d.cur_addr = addr_sel;
                state_d.limit    = (seg_count > CNT_W'(NSEG)) ? CNT_W'(NSEG) : seg_count;
            end
        end else if (state_q.idx == state_q.limit) begin
            state_d.busy    = 1'b0;
            state_d.done    = 1'b1;
            state_d.residue = state_q.acc;
        end else begin
            if (state_q.found) begin
                state_d.acc = state_q.acc + RES_W'(cur_len);
            end else if (cur_hit) begin
                state_d.acc   = state_q.acc + RES_W'(cur_remain);
                state_d.found = 1'b1;
            end
            state_d.idx = state_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign residue   = state_q.residue;
    assign done      = state_q.done;
    assign scan_busy = state_q.busy;

    logic unused_which;
    assign unused_which = (which == BUF_B);
endmodule

// File: rtl/dma_residue_calc_chk.sv
module dma_residue_calc_chk #(
    parameter int unsigned RES_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             done,
    input logic             busy,
    input logic [RES_W-1:0] residue
);
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_scan_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_hold_residue_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(residue));

    p_idle_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_done_needs_scan_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));
endmodule

bind dma_residue_calc dma_residue_calc_chk #(.RES_W(RES_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .done    (done),
    .busy    (scan_busy),
    .residue (residue)
);

// File: tb/dma_residue_calc_bench.sv
`timescale 1ns/1ps
module dma_residue_calc_bench;
    localparam int unsigned ADDR_W = 16;
    localparam int unsigned LEN_W  = 13;
    localparam int unsigned NSEG   = 4;
    localparam int unsigned CNT_W  = $clog2(NSEG + 1);
    localparam int unsigned RES_W  = LEN_W + CNT_W;

    typedef struct packed {
        logic [2:0]  st;     // {in_use, armed_a, armed_b}
        logic [15:0] a;
        logic [15:0] b;
        logic [2:0]  cnt;
        logic [15:0] exp;
    } vec_t;

    // Fixed table: 0x100+0x40, 0x200+0x80, 0x300+0x20, 0x400+0x10
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{3'b010, 16'h0110, 16'h0250, 3'd4, 16'h00E0}, // R1 R4 A: armed_a, not in use
        '{3'b100, 16'h0250, 16'h0100, 3'd4, 16'h0060}, // R1 A: in use, B not armed
        '{3'b111, 16'h0110, 16'h031F, 3'd4, 16'h0011}, // R2 B: in use, B armed
        '{3'b000, 16'h0110, 16'h0400, 3'd4, 16'h0010}, // R2 R3 B at segment base
        '{3'b010, 16'h0500, 16'h0110, 3'd4, 16'h0000}, // R5 no match
        '{3'b010, 16'h0110, 16'h0000, 3'd2, 16'h00B0}, // R6 count limits sum
        '{3'b010, 16'h0140, 16'h0000, 3'd4, 16'h0000}, // R3 end address excluded
        '{3'b010, 16'h0110, 16'h0000, 3'd0, 16'h0000}, // R6 count zero
        '{3'b010, 16'h0300, 16'h0000, 3'd2, 16'h0000}, // R6 segment beyond count
        '{3'b010, 16'h0400, 16'h0000, 3'd7, 16'h0010}  // R6 count clamped to NSEG
    };

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   start = 1'b0;
    logic                   in_use = 1'b0, armed_a = 1'b0, armed_b = 1'b0;
    logic [ADDR_W-1:0]      addr_a = '0, addr_b = '0;
    logic [NSEG*ADDR_W-1:0] seg_base;
    logic [NSEG*LEN_W-1:0]  seg_len;
    logic [CNT_W-1:0]       seg_count = '0;
    logic [RES_W-1:0]       residue;
    logic                   done;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    assign seg_base = {16'h0400, 16'h0300, 16'h0200, 16'h0100};
    assign seg_len  = {13'h010, 13'h020, 13'h080, 13'h040};

    dma_residue_calc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .NSEG(NSEG)) u_dma_residue_calc (
        .clk(clk), .rst_n(rst_n), .start(start), .in_use(in_use),
        .armed_a(armed_a), .armed_b(armed_b), .addr_a(addr_a), .addr_b(addr_b),
        .seg_base(seg_base), .seg_len(seg_len), .seg_count(seg_count),
        .residue(residue), .done(done)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drives one computation and checks latency and result.
    task automatic run(input vec_t v, input string tag);
        int k;
        int eff;
        eff = (v.cnt > NSEG) ? NSEG : int'(v.cnt);
        @(negedge clk);
        {in_use, armed_a, armed_b} = v.st;
        addr_a = v.a; addr_b = v.b; seg_count = v.cnt[CNT_W-1:0];
        start = 1'b1;
        k = 0;
        for (int n = 1; n <= 40; n++) begin
            @(negedge clk);
            start = 1'b0;
            if (done) begin k = n; break; end
        end
        check({tag, " R7 latency"}, k, eff + 2);
        check({tag, " residue"}, 32'(residue), 32'(v.exp));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int k;
        logic [RES_W-1:0] held;
        repeat (3) @(negedge clk);
        check("R8 reset residue", 32'(residue), 0);
        check("R8 reset done", 32'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run(VECS[i], $sformatf("vec%0d", i));
        end

        // R8: residue held while inputs change and no scan runs
        held = residue;
        addr_a = 16'h0210; in_use = 1'b1;
        repeat (5) @(negedge clk);
        check("R8 hold residue", 32'(residue), 32'(held));
        check("R8 done low", 32'(done), 0);

        // R9 R10: start and address changes during a scan are ignored
        @(negedge clk);
        {in_use, armed_a, armed_b} = 3'b010;
        addr_a = 16'h0110; seg_count = 3'd4;
        start = 1'b1;
        k = 0;
        for (int n = 1; n <= 40; n++) begin
            @(negedge clk);
            start = (n == 2);
            if (n == 2) begin addr_a = 16'h0300; addr_b = 16'h0300; armed_a = 1'b0; end
            if (done) begin k = n; break; end
        end
        start = 1'b0;
        check("R9 latency unchanged", k, NSEG + 2);
        check("R10 original address used", 32'(residue), 32'h00E0);
        k = 0;
        for (int n = 1; n <= 10; n++) begin
            @(negedge clk);
            if (done) k++;
        end
        check("R9 no extra done", k, 0);
        check("R7 done pulse ended", 32'(done), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule